// File: doc/BRIEF.md
# Three-Wire Serial Bus Master

This block drives a three-wire synchronous bus toward a clock-and-RAM peripheral. The bus has a level chip enable, a serial clock and one data line whose direction changes mid-transaction. A host hands over a command byte, a byte count and a direction. The master raises the enable with the serial clock parked low and shifts the command out least significant bit first. It then either shifts out write bytes pulled from a ready/valid stream, or releases the data line and assembles read bytes that leave on a ready/valid stream. When the last byte is done it drops the enable.

The host sets the serial clock speed at run time. Each clock phase lasts a programmable number of system cycles. One enable window carries from 1 to 32 data bytes, so single-register accesses and whole-group bursts use the same path. A configurable counter keeps the enable low for a minimum time between transactions. When the read stream stalls, the serial clock is frozen low, so no byte is ever lost.

Top module: `tw_bus_master`

## Requirements
- R1: `ceOut` rises while `sclkOut` is low, `sclkOut` is low whenever `ceOut` is low, and `ceOut` falls only after the serial clock has been low for one phase following the final pulse.
- R2: The first eight serial clock pulses of every transaction carry `cmdByte`, least significant bit first, with `sioOe` high.
- R3: On a write (`cmdRead`=0), each data byte goes out least significant bit first after the command. Each bit is set up while `sclkOut` is low and held constant for the whole high phase.
- R4: On a read (`cmdRead`=1), `sioOe` is low after the command. One bit of `sioIn` is sampled at the end of each low phase that follows a falling edge. Bits shift in from the top, so the first bit received lands in `rdData[0]`.
- R5: A transaction carries `cmdBytesM1`+1 data bytes (1 to 32) and produces exactly 8×(`cmdBytesM1`+2) serial clock pulses.
- R6: Every serial clock high phase lasts `halfCycles`+1 system cycles. Every low phase lasts at least that long.
- R7: `sioOe` changes only while `sclkOut` is low. It is high at every rising edge during the command and during write data.
- R8: While `rdValid` is high and `rdReady` is low, `rdValid` and `rdData` hold their values and `sclkOut` stays low.
- R9: `wrReady` is raised only inside an enable window with `sclkOut` low. The serial clock does not advance until a write byte is accepted.
- R10: `busy` equals the enable window. `cmdReady` is never high while `busy` is high, and after reset the block is idle with `cmdReady` high.
- R11: Between one transaction's enable fall and the next rise, `ceOut` stays low for at least `MIN_GAP` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| halfCycles | input | DIV_W | Serial clock phase length minus one, in system cycles |
| cmdValid | input | 1 | Host offers a transaction |
| cmdReady | output | 1 | Master can accept a transaction |
| cmdByte | input | 8 | Command byte sent first |
| cmdBytesM1 | input | $clog2(MAX_BYTES) | Data byte count minus one |
| cmdRead | input | 1 | 1 = read data bytes, 0 = write data bytes |
| wrValid | input | 1 | Write byte available |
| wrReady | output | 1 | Master takes the write byte |
| wrData | input | 8 | Write byte |
| rdValid | output | 1 | Read byte available |
| rdReady | input | 1 | Host takes the read byte |
| rdData | output | 8 | Read byte |
| busy | output | 1 | Enable window active |
| ceOut | output | 1 | Bus chip enable |
| sclkOut | output | 1 | Bus serial clock |
| sioOut | output | 1 | Data line value when driven |
| sioOe | output | 1 | Data line drive enable |
| sioIn | input | 1 | Data line value from the pad |

## Verification
The bench builds the block with `DIV_W`=4 and `MIN_GAP`=5. It varies `halfCycles` from 0 up to the 4-bit ceiling of 15 between transactions. The zero setting gives single-cycle phases, where a read bit is sampled one cycle after the falling edge. The ceiling exercises the full width of the divider counter. With a 5-bit count field, full 32-byte bursts are reachable in both directions. The gap of 5 cycles is small enough that back-to-back commands run straight into the enable-low limit.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_WAITWR,
    ST_WAITRD,
    ST_TAIL
  } twState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic loadWr;
    logic reloadTimer;
    logic shiftOut;
    logic sampleIn;
    logic bitNext;
    logic byteNext;
    logic endCmd;
    logic startGap;
  } twStrobe_t;

endpackage

// File: rtl/tw_datapath.sv
module tw_datapath
  import tw_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int MAX_BYTES = 32,
  parameter int MIN_GAP   = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  twStrobe_t                    stb,
  input  logic [DIV_W-1:0]             halfCycles,
  input  logic [7:0]                   cmdByte,
  input  logic [$clog2(MAX_BYTES)-1:0] cmdBytesM1,
  input  logic                         cmdRead,
  input  logic [7:0]                   wrData,
  input  logic                         sioIn,
  output logic                         phaseDone,
  output logic                         lastBit,
  output logic                         lastByte,
  output logic                         gapDone,
  output logic                         inCmd,
  output logic                         isRead,
  output logic [7:0]                   shiftReg
);

  localparam int LEN_W = $clog2(MAX_BYTES);
  localparam int GAP_W = $clog2(MIN_GAP + 2);

  logic [DIV_W-1:0] phaseCnt;
  logic [2:0]       bitCnt;
  logic [LEN_W-1:0] bytesLeft;
  logic [GAP_W-1:0] gapCnt;

  assign phaseDone = (phaseCnt == '0);
  assign lastBit   = (bitCnt == 3'd7);
  assign lastByte  = (bytesLeft == '0);
  assign gapDone   = (gapCnt == '0);

  // phase timer: reload, then count down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (stb.loadCmd || stb.reloadTimer) begin
      phaseCnt <= halfCycles;
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - DIV_W'(1);
    end
  end

  // shifter, bit and byte counters, mode flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      bytesLeft <= '0;
      isRead    <= 1'b0;
      inCmd     <= 1'b0;
    end else if (stb.loadCmd) begin
      shiftReg  <= cmdByte;
      bitCnt    <= '0;
      bytesLeft <= cmdBytesM1;
      isRead    <= cmdRead;
      inCmd     <= 1'b1;
    end else begin
      if (stb.loadWr) begin
        shiftReg <= wrData;
      end else if (stb.sampleIn) begin
        shiftReg <= {sioIn, shiftReg[7:1]};
      end else if (stb.shiftOut) begin
        shiftReg <= {1'b0, shiftReg[7:1]};
      end
      if (stb.bitNext)  bitCnt    <= bitCnt + 3'd1;
      if (stb.byteNext) bytesLeft <= bytesLeft - LEN_W'(1);
      if (stb.endCmd)   inCmd     <= 1'b0;
    end
  end

  // enable-low spacing counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (stb.startGap) begin
      gapCnt <= GAP_W'(MIN_GAP);
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - GAP_W'(1);
    end
  end

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      wrValid,
  input  logic      rdReady,
  input  logic      phaseDone,
  input  logic      lastBit,
  input  logic      lastByte,
  input  logic      gapDone,
  input  logic      inCmd,
  input  logic      isRead,
  output twStrobe_t stb,
  output logic      cmdReady,
  output logic      wrReady,
  output logic      rdValid,
  output logic      ceOut,
  output logic      sclkOut,
  output logic      sioOe
);

  twState_t state, stateNext;
  logic     ceReg;
  logic     driving;

  assign driving  = inCmd || !isRead;
  assign cmdReady = (state == ST_IDLE) && gapDone;
  assign wrReady  = (state == ST_WAITWR);
  assign rdValid  = (state == ST_WAITRD);
  assign sclkOut  = (state == ST_HIGH);
  assign ceOut    = ceReg;
  assign sioOe    = driving &&
                    ((state == ST_LOW) || (state == ST_HIGH) || (state == ST_WAITWR));

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid && gapDone) begin
          stb.loadCmd = 1'b1;
          stateNext   = ST_LOW;
        end
      end
      ST_LOW: begin
        if (phaseDone) begin
          if (!driving) begin
            stb.sampleIn = 1'b1;
            if (lastBit) begin
              stateNext = ST_WAITRD;
            end else begin
              stb.reloadTimer = 1'b1;
              stateNext       = ST_HIGH;
            end
          end else begin
            stb.reloadTimer = 1'b1;
            stateNext       = ST_HIGH;
          end
        end
      end
      ST_WAITRD: begin
        if (rdReady) begin
          stb.reloadTimer = 1'b1;
          stateNext       = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (phaseDone) begin
          stb.bitNext = 1'b1;
          if (!lastBit) begin
            stb.shiftOut    = driving;
            stb.reloadTimer = 1'b1;
            stateNext       = ST_LOW;
          end else if (inCmd) begin
            stb.endCmd = 1'b1;
            if (isRead) begin
              stb.reloadTimer = 1'b1;
              stateNext       = ST_LOW;
            end else begin
              stateNext = ST_WAITWR;
            end
          end else if (lastByte) begin
            stb.reloadTimer = 1'b1;
            stateNext       = ST_TAIL;
          end else begin
            stb.byteNext = 1'b1;
            if (isRead) begin
              stb.reloadTimer = 1'b1;
              stateNext       = ST_LOW;
            end else begin
              stateNext = ST_WAITWR;
            end
          end
        end
      end
      ST_WAITWR: begin
        if (wrValid) begin
          stb.loadWr      = 1'b1;
          stb.reloadTimer = 1'b1;
          stateNext       = ST_LOW;
        end
      end
      ST_TAIL: begin
        if (phaseDone) begin
          stb.startGap = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ceReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.loadCmd)       ceReg <= 1'b1;
      else if (stb.startGap) ceReg <= 1'b0;
    end
  end

endmodule

// File: rtl/tw_bus_master.sv
module tw_bus_master
  import tw_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int MAX_BYTES = 32,
  parameter int MIN_GAP   = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [DIV_W-1:0]             halfCycles,
  input  logic                         cmdValid,
  output logic                         cmdReady,
  input  logic [7:0]                   cmdByte,
  input  logic [$clog2(MAX_BYTES)-1:0] cmdBytesM1,
  input  logic                         cmdRead,
  input  logic                         wrValid,
  output logic                         wrReady,
  input  logic [7:0]                   wrData,
  output logic                         rdValid,
  input  logic                         rdReady,
  output logic [7:0]                   rdData,
  output logic                         busy,
  output logic                         ceOut,
  output logic                         sclkOut,
  output logic                         sioOut,
  output logic                         sioOe,
  input  logic                         sioIn
);

  twStrobe_t  stb;
  logic       phaseDone, lastBit, lastByte, gapDone, inCmd, isRead;
  logic [7:0] shiftReg;

  tw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .wrValid  (wrValid),
    .rdReady  (rdReady),
    .phaseDone(phaseDone),
    .lastBit  (lastBit),
    .lastByte (lastByte),
    .gapDone  (gapDone),
    .inCmd    (inCmd),
    .isRead   (isRead),
    .stb      (stb),
    .cmdReady (cmdReady),
    .wrReady  (wrReady),
    .rdValid  (rdValid),
    .ceOut    (ceOut),
    .sclkOut  (sclkOut),
    .sioOe    (sioOe)
  );

  tw_datapath #(
    .DIV_W    (DIV_W),
    .MAX_BYTES(MAX_BYTES),
    .MIN_GAP  (MIN_GAP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .halfCycles(halfCycles),
    .cmdByte   (cmdByte),
    .cmdBytesM1(cmdBytesM1),
    .cmdRead   (cmdRead),
    .wrData    (wrData),
    .sioIn     (sioIn),
    .phaseDone (phaseDone),
    .lastBit   (lastBit),
    .lastByte  (lastByte),
    .gapDone   (gapDone),
    .inCmd     (inCmd),
    .isRead    (isRead),
    .shiftReg  (shiftReg)
  );

  assign sioOut = shiftReg[0];
  assign rdData = shiftReg;
  assign busy   = ceOut;

endmodule

// File: rtl/tw_checker.sv
module tw_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ceOut,
  input logic       sclkOut,
  input logic       sioOe,
  input logic       sioOut,
  input logic       rdValid,
  input logic       rdReady,
  input logic [7:0] rdData,
  input logic       wrReady,
  input logic       cmdReady,
  input logic       busy
);

  assert_ce_rise_sclk_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ceOut) |-> !sclkOut);

  assert_sclk_parked_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ceOut |-> !sclkOut);

  assert_wdata_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOut && $past(sclkOut)) |-> $stable(sioOut));

  assert_oe_turn_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sioOe != $past(sioOe)) |-> !sclkOut);

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));

  assert_rd_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !sclkOut);

  assert_wr_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> (ceOut && !sclkOut));

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !busy);

  assert_stream_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdValid, wrReady, cmdReady}));

endmodule

bind tw_bus_master tw_checker u_chk (.*);

// File: tb/sim_tw_bus_master.sv
module sim_tw_bus_master;
  localparam int DIV_W     = 4;
  localparam int MAX_BYTES = 32;
  localparam int MIN_GAP   = 5;
  localparam int LEN_W     = $clog2(MAX_BYTES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [DIV_W-1:0] halfCycles = '0;
  logic             cmdValid = 1'b0;
  logic [7:0]       cmdByte = '0;
  logic [LEN_W-1:0] cmdBytesM1 = '0;
  logic             cmdRead = 1'b0;
  logic             wrValid = 1'b0;
  logic [7:0]       wrData = '0;
  logic             rdReady = 1'b0;
  logic             sioIn = 1'b0;
  logic cmdReady, wrReady, rdValid, busy, ceOut, sclkOut, sioOut, sioOe;
  logic [7:0] rdData;

  tw_bus_master #(.DIV_W(DIV_W), .MAX_BYTES(MAX_BYTES), .MIN_GAP(MIN_GAP)) u0 (
    .clk(clk), .rstN(rstN), .halfCycles(halfCycles),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdByte(cmdByte),
    .cmdBytesM1(cmdBytesM1), .cmdRead(cmdRead),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .busy(busy), .ceOut(ceOut), .sclkOut(sclkOut),
    .sioOut(sioOut), .sioOe(sioOe), .sioIn(sioIn)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdModel(input logic [7:0] c, input int k);
    return c ^ 8'(k * 29) ^ 8'h5A;
  endfunction

  // ---------------- peripheral model ----------------
  bit         curRead = 1'b0;
  int         curHalf = 0;
  int         sBits = 0, pulses = 0, rdBitIdx = 0, gotWrN = 0, oeErr = 0;
  logic [7:0] sSh = '0, gotCmd = '0, sTmp = '0;
  logic [7:0] gotWr [MAX_BYTES];

  always @(posedge ceOut) begin
    sBits = 0; pulses = 0; rdBitIdx = 0; gotWrN = 0;
  end

  always @(posedge sclkOut) if (ceOut) begin
    pulses++;
    if (sBits < 8 || !curRead) begin
      if (sioOe !== 1'b1) oeErr++;
      sSh = {sioOut, sSh[7:1]};
      sBits++;
      if (sBits == 8) gotCmd = sSh;
      else if ((sBits % 8) == 0 && gotWrN < MAX_BYTES) begin
        gotWr[gotWrN] = sSh;
        gotWrN++;
      end
    end else if (sioOe !== 1'b0) oeErr++;
  end

  always @(negedge sclkOut) if (ceOut && curRead && sBits >= 8) begin
    sTmp  = rdModel(gotCmd, rdBitIdx / 8);
    sioIn = sTmp[rdBitIdx % 8];
    rdBitIdx++;
  end

  // ---------------- bus monitor ----------------
  int frameErr = 0, hiErr = 0, stallErr = 0, wrErr = 0, busyErr = 0, gapErr = 0;
  int hiRun = 0, loRun = 0;
  bit prevCe = 1'b0, prevSclk = 1'b0, prevStall = 1'b0, seenFall = 1'b0;
  logic [7:0] prevRd = '0;

  always @(negedge clk) if (rstN) begin
    if (busy !== ceOut) busyErr++;
    if (cmdReady && busy) busyErr++;
    if (!ceOut && sclkOut) frameErr++;
    if (ceOut && !prevCe && sclkOut) frameErr++;
    if (!ceOut && prevCe && prevSclk) frameErr++;
    if (sclkOut) hiRun++;
    else if (prevSclk) begin
      if (hiRun != curHalf + 1) hiErr++;
      hiRun = 0;
    end
    if (!ceOut) loRun++;
    if (!ceOut && prevCe) seenFall = 1'b1;
    if (ceOut && !prevCe) begin
      if (seenFall && loRun < MIN_GAP) gapErr++;
      loRun = 0;
    end
    if (prevStall && (sclkOut || !rdValid || rdData !== prevRd)) stallErr++;
    if (wrReady && (sclkOut || !ceOut)) wrErr++;
    prevStall = rdValid && !rdReady;
    prevRd    = rdData;
    prevCe    = ceOut;
    prevSclk  = sclkOut;
  end

  // ---------------- host driver ----------------
  logic [7:0] wrBytes [MAX_BYTES];
  logic [7:0] rdGot   [MAX_BYTES];

  task automatic runTxn(input logic [7:0] cmd, input int n, input bit rd,
                        input int half, input int idle);
    for (int k = 0; k < n; k++) wrBytes[k] = 8'($urandom);
    repeat (idle) @(posedge clk);
    frameErr = 0; hiErr = 0; stallErr = 0; wrErr = 0; busyErr = 0;
    gapErr = 0; oeErr = 0;
    @(posedge clk); #1;
    curHalf = half; curRead = rd; halfCycles = DIV_W'(half);
    cmdValid = 1'b1; cmdByte = cmd; cmdBytesM1 = LEN_W'(n - 1); cmdRead = rd;
    do @(negedge clk); while (!cmdReady);
    @(posedge clk); #1;
    cmdValid = 1'b0;
    fork
      begin
        if (!rd) begin
          for (int k = 0; k < n; k++) begin
            repeat ($urandom % 4) @(posedge clk);
            #1; wrValid = 1'b1; wrData = wrBytes[k];
            do @(negedge clk); while (!wrReady);
            @(posedge clk); #1; wrValid = 1'b0;
          end
        end
      end
      begin
        if (rd) begin
          int k = 0;
          while (k < n) begin
            @(posedge clk); #1;
            rdReady = ($urandom % 3) != 0;
            @(negedge clk);
            if (rdValid && rdReady) begin
              rdGot[k] = rdData;
              k++;
            end
          end
          @(posedge clk); #1; rdReady = 1'b0;
        end
      end
    join
    while (ceOut) @(negedge clk);
    check(gotCmd == cmd, "R2", "command byte", int'(gotCmd), int'(cmd));
    for (int k = 0; k < n; k++) begin
      if (rd) check(rdGot[k] == rdModel(cmd, k), "R4", "read byte",
                    int'(rdGot[k]), int'(rdModel(cmd, k)));
      else    check(gotWr[k] == wrBytes[k], "R3", "write byte",
                    int'(gotWr[k]), int'(wrBytes[k]));
    end
    check(pulses == 8 * (n + 1), "R5", "pulse count", pulses, 8 * (n + 1));
    check(hiErr == 0, "R6", "high phase length errors", hiErr, 0);
    check(oeErr == 0, "R7", "drive enable at rising edge", oeErr, 0);
    check(stallErr == 0, "R8", "read stall errors", stallErr, 0);
    check(wrErr == 0, "R9", "write request errors", wrErr, 0);
    check(busyErr == 0, "R10", "busy window errors", busyErr, 0);
    check(frameErr == 0, "R1", "framing errors", frameErr, 0);
    check(gapErr == 0, "R11", "enable gap errors", gapErr, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(ceOut == 1'b0 && sclkOut == 1'b0, "R1", "reset bus idle",
          int'({ceOut, sclkOut}), 0);
    check(busy == 1'b0 && cmdReady == 1'b1, "R10", "reset ready",
          int'({busy, cmdReady}), 1);
    check(rdValid == 1'b0, "R8", "reset rdValid", int'(rdValid), 0);
    check(wrReady == 1'b0, "R9", "reset wrReady", int'(wrReady), 0);

    runTxn(8'h80, 1, 1'b0, 1, 0);
    runTxn(8'h81, 1, 1'b1, 0, 0);
    runTxn(8'hBF, 8, 1'b1, 2, 0);
    runTxn(8'hFE, 31, 1'b0, 0, 3);
    runTxn(8'hFF, 32, 1'b1, 1, 0);
    runTxn(8'h3C, 32, 1'b0, 15, 0);
    runTxn(8'hC1, 2, 1'b1, 15, 0);
    for (int t = 0; t < 16; t++) begin
      bit rd = 1'($urandom % 2);
      logic [7:0] c = {7'($urandom), rd};
      runTxn(c, 1 + int'($urandom % 32), rd, int'($urandom % 4),
             ($urandom % 2) ? 0 : int'($urandom % 10));
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule